// File: doc/BRIEF.md
# Modem-Status Scanning Multiplexer

This block watches the modem inputs of sixteen serial lines: ring, carrier, clear-to-send and secondary receive. It also holds each line's four modem outputs: line enable, data-terminal-ready, request-to-send and secondary transmit. Once enabled, a scanner visits one line per clock. It compares that line's inputs with a stored reference copy. When it finds a difference it stops on that line and latches the line number and a mask of the inputs that changed. It then sets a done flag, and raises an interrupt if interrupts are enabled. Software takes the event and writes the control word again to resume scanning.

Host access uses two registers. A write with `regSel` low goes to the control word. A write with `regSel` high goes to the status of the currently selected line. To change a line's outputs, software first drops scan enable and waits for busy to read zero. It then selects the line through the line field of the control word, and then writes the line-status register. Both registers can always be read on `ctrlRd` and `lineRd`.

Top module: `msm_scanner`

## Requirements
- R1: After reset the control word reads 0x0000, `irq` is low and every modem output is low.
- R2: While scan enable (control bit 5) is 1 and done (bit 7) is 0, each clock edge takes one step. With no change found, the line field (bits 3:0) advances by one and wraps from line 15 to line 0. Busy (bit 4) reads 1 in the cycle after every step and 0 in the cycle after any cycle with no step.
- R3: A step that finds a difference on line L sets done. It leaves the line field at L and loads bits 15:12 with the change mask: 15 ring, 14 carrier, 13 clear-to-send, 12 secondary receive. While done is 1, the line field and the mask hold.
- R4: A line's reference copy is refreshed only when a change on that line is reported. A change that occurs while the scanner is stopped is reported after scanning resumes. A change that has already been reported is not reported again.
- R5: `irq` equals done AND interrupt enable (control bit 6).
- R6: A control write without the clear bits loads the line field, interrupt enable, scan enable and done from the written word. If the written done bit is 0, the change mask is cleared. Writing bits 6 and 5 set with bit 7 clear restarts scanning from the written line.
- R7: A control write with done and interrupt enable both set forces `irq` high while scan enable is 0, and no scanning takes place.
- R8: A line-status write with scan enable 0 and busy 0 loads the selected line's outputs from bits 3:0: bit 3 secondary transmit, bit 2 request-to-send, bit 1 data-terminal-ready, bit 0 line enable. `lineRd` shows the selected line's live inputs in bits 7:4 (7 ring, 6 carrier, 5 clear-to-send, 4 secondary receive) and its outputs in bits 3:0.
- R9: A line-status write made while scan enable or busy is 1 is ignored and no output changes.
- R10: A control write with bit 11 (clear scan) set clears the line field, done, the change mask, scan enable and busy. It loads interrupt enable from bit 6 and leaves the modem outputs unchanged.
- R11: A control write with bit 10 (clear multiplexer) set does everything clear scan does, and also sets every output of every line to 0.
- R12: A control write in the same cycle as a step that would find a change wins over the step. No change is recorded, the reference copy is left as it was, and the change is reported by a later scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control word, 1 selects the line-status register |
| wrData | input | 16 | Write data |
| ctrlRd | output | 16 | Control word readback |
| lineRd | output | 8 | Status of the selected line |
| irq | output | 1 | Interrupt request |
| ringIn | input | 16 | Ring input, one bit per line |
| carrierIn | input | 16 | Carrier-detect input, one bit per line |
| ctsIn | input | 16 | Clear-to-send input, one bit per line |
| secRxIn | input | 16 | Secondary-receive input, one bit per line |
| dtrOut | output | 16 | Data-terminal-ready output, one bit per line |
| rtsOut | output | 16 | Request-to-send output, one bit per line |
| lineEnOut | output | 16 | Line-enable output, one bit per line |
| secTxOut | output | 16 | Secondary-transmit output, one bit per line |

## Verification
A scanner step that would find a change can fall in the same cycle as a host write to the control word. The bench provokes this by pointing the scanner at line 4 and then, in the next cycle, both toggling that line's clear-to-send input and writing a control word that pauses scanning. The result is judged by confirming that done stays clear with an empty change mask in that cycle, and that the same change is reported on line 4 after the next restart. A cycle-level reference model, compared on every clock, also judges the other overlaps: host writes landing on scanning cycles, and a stop step followed at once by a restart.

// File: rtl/msm_pkg.sv
package msm_pkg;
  // control-word bit positions decoded by the controller
  localparam int BIT_CLRSCAN = 11;
  localparam int BIT_CLRMUX  = 10;
  localparam int BIT_DONE    = 7;
  localparam int BIT_IE      = 6;
  localparam int BIT_SE      = 5;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic commit;   // refresh reference copy of the current line
    logic clrOut;   // zero every line output register
    logic lsWrite;  // load current line's outputs from write data
  } msmStrobe_t;
endpackage

// File: rtl/msm_dp.sv
module msm_dp
  import msm_pkg::*;
#(
  parameter int NLINES = 16,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  msmStrobe_t        strobe,
  input  logic [LW-1:0]     line,
  input  logic [3:0]        wrBits,
  input  logic [NLINES-1:0] ringIn,
  input  logic [NLINES-1:0] carrierIn,
  input  logic [NLINES-1:0] ctsIn,
  input  logic [NLINES-1:0] secRxIn,
  output logic [3:0]        changeMask,
  output logic [7:0]        lineStat,
  output logic [NLINES-1:0] dtrOut,
  output logic [NLINES-1:0] rtsOut,
  output logic [NLINES-1:0] lineEnOut,
  output logic [NLINES-1:0] secTxOut
);
  logic [3:0] curVec   [NLINES];
  logic [3:0] refState [NLINES];
  logic [3:0] outReg   [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign curVec[i]    = {ringIn[i], carrierIn[i], ctsIn[i], secRxIn[i]};
    assign secTxOut[i]  = outReg[i][3];
    assign rtsOut[i]    = outReg[i][2];
    assign dtrOut[i]    = outReg[i][1];
    assign lineEnOut[i] = outReg[i][0];
  end

  assign changeMask = curVec[line] ^ refState[line];
  assign lineStat   = {curVec[line], outReg[line]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NLINES; i++) refState[i] <= '0;
    end else if (strobe.commit) begin
      refState[line] <= curVec[line];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NLINES; i++) outReg[i] <= '0;
    end else if (strobe.clrOut) begin
      for (int i = 0; i < NLINES; i++) outReg[i] <= '0;
    end else if (strobe.lsWrite) begin
      outReg[line] <= wrBits;
    end
  end
endmodule

// File: rtl/msm_ctrl.sv
module msm_ctrl
  import msm_pkg::*;
#(
  parameter int NLINES = 16,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regSel,
  input  logic [15:0]   wrData,
  input  logic [3:0]    changeMask,
  output msmStrobe_t    strobe,
  output logic [LW-1:0] linePtr,
  output logic [15:0]   ctrlWord,
  output logic          irq
);
  logic       scanEn, intEn, done, busy;
  logic [3:0] flags;
  logic       ctlWr, scanActive, changeSeen;
  logic [LW-1:0] nextLine;

  assign ctlWr      = regWr && !regSel;
  assign scanActive = scanEn && !done && !ctlWr;
  assign changeSeen = |changeMask;
  assign nextLine   = (linePtr == LW'(NLINES - 1)) ? '0 : linePtr + 1'b1;

  assign strobe.commit  = scanActive && changeSeen;
  assign strobe.clrOut  = ctlWr && wrData[BIT_CLRMUX];
  assign strobe.lsWrite = regWr && regSel && !scanEn && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linePtr <= '0;
      scanEn  <= 1'b0;
      intEn   <= 1'b0;
      done    <= 1'b0;
      busy    <= 1'b0;
      flags   <= '0;
    end else if (ctlWr) begin
      busy  <= 1'b0;
      intEn <= wrData[BIT_IE];
      if (wrData[BIT_CLRSCAN] || wrData[BIT_CLRMUX]) begin
        linePtr <= '0;
        done    <= 1'b0;
        scanEn  <= 1'b0;
        flags   <= '0;
      end else begin
        linePtr <= wrData[LW-1:0];
        done    <= wrData[BIT_DONE];
        scanEn  <= wrData[BIT_SE];
        if (!wrData[BIT_DONE]) flags <= '0;
      end
    end else if (scanActive) begin
      busy <= 1'b1;
      if (changeSeen) begin
        done  <= 1'b1;
        flags <= changeMask;
      end else begin
        linePtr <= nextLine;
      end
    end else begin
      busy <= 1'b0;
    end
  end

  assign ctrlWord = {flags, 4'b0000, done, intEn, scanEn, busy, 4'(linePtr)};
  assign irq      = done && intEn;
endmodule

// File: rtl/msm_scanner.sv
module msm_scanner
  import msm_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regSel,
  input  logic [15:0]       wrData,
  output logic [15:0]       ctrlRd,
  output logic [7:0]        lineRd,
  output logic              irq,
  input  logic [NLINES-1:0] ringIn,
  input  logic [NLINES-1:0] carrierIn,
  input  logic [NLINES-1:0] ctsIn,
  input  logic [NLINES-1:0] secRxIn,
  output logic [NLINES-1:0] dtrOut,
  output logic [NLINES-1:0] rtsOut,
  output logic [NLINES-1:0] lineEnOut,
  output logic [NLINES-1:0] secTxOut
);
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1;

  msmStrobe_t    strobe;
  logic [LW-1:0] linePtr;
  logic [3:0]    changeMask;

  msm_ctrl #(.NLINES(NLINES)) ctrlInst (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .wrData(wrData),
    .changeMask(changeMask), .strobe(strobe), .linePtr(linePtr),
    .ctrlWord(ctrlRd), .irq(irq)
  );

  msm_dp #(.NLINES(NLINES)) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .line(linePtr), .wrBits(wrData[3:0]),
    .ringIn(ringIn), .carrierIn(carrierIn), .ctsIn(ctsIn), .secRxIn(secRxIn),
    .changeMask(changeMask), .lineStat(lineRd),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .lineEnOut(lineEnOut), .secTxOut(secTxOut)
  );
endmodule

// File: rtl/msm_scanner_chk.sv
module msm_scanner_chk #(
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic              regSel,
  input logic [15:0]       wrData,
  input logic [15:0]       ctrlRd,
  input logic              irq,
  input logic [NLINES-1:0] dtrOut,
  input logic [NLINES-1:0] rtsOut,
  input logic [NLINES-1:0] lineEnOut,
  input logic [NLINES-1:0] secTxOut
);
  function automatic logic [3:0] nextOf(input logic [3:0] v);
    return (v == 4'(NLINES - 1)) ? 4'd0 : v + 4'd1;
  endfunction

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlRd[7] && ctrlRd[6]));

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[7] && !regWr) |=> (ctrlRd[7] && $stable(ctrlRd[3:0]) && $stable(ctrlRd[15:12])));

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[5] && !ctrlRd[7] && !(regWr && !regSel))
      |=> (ctrlRd[4] && (ctrlRd[7] || ctrlRd[3:0] == nextOf($past(ctrlRd[3:0])))));

  // R9
  ls_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel && (ctrlRd[5] || ctrlRd[4]))
      |=> $stable({dtrOut, rtsOut, lineEnOut, secTxOut}));

  // R10
  clear_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSel && wrData[11]) |=> ((ctrlRd & 16'hF0BF) == 16'h0000));

  // R11
  clear_mux_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSel && wrData[10]) |=> ({dtrOut, rtsOut, lineEnOut, secTxOut} == '0));
endmodule

bind msm_scanner msm_scanner_chk #(.NLINES(NLINES)) chkInst (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .wrData(wrData),
  .ctrlRd(ctrlRd), .irq(irq), .dtrOut(dtrOut), .rtsOut(rtsOut),
  .lineEnOut(lineEnOut), .secTxOut(secTxOut)
);

// File: tb/msm_scanner_test.sv
module msm_scanner_test;
  localparam int N = 16;
  localparam time PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [N-1:0] ring = '0, car = '0, cts = '0, srx = '0;
  logic [15:0] ctrlRd;
  logic [7:0]  lineRd;
  logic irq;
  logic [N-1:0] dtrOut, rtsOut, lineEnOut, secTxOut;

  int checks = 0, fails = 0, cycles = 0;

  always #(PERIOD / 2) clk = ~clk;

  msm_scanner #(.NLINES(N)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .wrData(wrData),
    .ctrlRd(ctrlRd), .lineRd(lineRd), .irq(irq),
    .ringIn(ring), .carrierIn(car), .ctsIn(cts), .secRxIn(srx),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .lineEnOut(lineEnOut), .secTxOut(secTxOut)
  );

  // behavioural reference model
  int mLine;
  bit mSe, mIe, mDone, mBusy;
  bit [3:0] mFlags;
  bit [3:0] mRef [N];
  bit [3:0] mOut [N];

  function automatic bit [3:0] curOf(int l);
    return {ring[l], car[l], cts[l], srx[l]};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLine = 0; mSe = 0; mIe = 0; mDone = 0; mBusy = 0; mFlags = 0;
      for (int i = 0; i < N; i++) begin mRef[i] = 0; mOut[i] = 0; end
    end else begin
      bit [3:0] cur;
      cur = curOf(mLine);
      if (regWr && regSel && !mSe && !mBusy) mOut[mLine] = wrData[3:0];
      if (regWr && !regSel) begin
        mBusy = 0;
        mIe = wrData[6];
        if (wrData[11] || wrData[10]) begin
          mLine = 0; mDone = 0; mSe = 0; mFlags = 0;
          if (wrData[10]) for (int i = 0; i < N; i++) mOut[i] = 0;
        end else begin
          mLine = int'(wrData[3:0]); mDone = wrData[7]; mSe = wrData[5];
          if (!wrData[7]) mFlags = 0;
        end
      end else if (mSe && !mDone) begin
        mBusy = 1;
        if (cur != mRef[mLine]) begin
          mFlags = cur ^ mRef[mLine];
          mRef[mLine] = cur;
          mDone = 1;
        end else begin
          mLine = (mLine + 1) % N;
        end
      end else begin
        mBusy = 0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      logic [N-1:0] eDtr, eRts, eLe, eStx;
      for (int i = 0; i < N; i++) begin
        eStx[i] = mOut[i][3]; eRts[i] = mOut[i][2];
        eDtr[i] = mOut[i][1]; eLe[i]  = mOut[i][0];
      end
      check("R3 control word", 32'(ctrlRd),
            32'({mFlags, 4'b0000, mDone, mIe, mSe, mBusy, 4'(mLine)}));
      check("R5 irq", 32'(irq), 32'(mDone && mIe));
      check("R8 line status", 32'(lineRd), 32'({curOf(mLine), mOut[mLine]}));
      check("R8 outputs", {eDtr, eRts}, {dtrOut, rtsOut});
      check("R11 outputs", {eLe, eStx}, {lineEnOut, secTxOut});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic busWrite(input logic sel, input logic [15:0] d);
    regWr = 1'b1; regSel = sel; wrData = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);
    // R1 reset state
    check("R1 ctrl after reset", 32'(ctrlRd), 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R1 outputs after reset", {dtrOut, rtsOut}, 32'h0);

    // R8 select line 5 and drive dtr+rts
    busWrite(1'b0, 16'h0005);
    busWrite(1'b1, 16'h0006);
    check("R8 dtr line5", 32'(dtrOut[5]), 32'h1);
    check("R8 rts line5", 32'(rtsOut[5]), 32'h1);
    check("R8 lineRd line5", 32'(lineRd), 32'h06);

    // R3 carrier change on line 9
    car[9] = 1'b1;
    busWrite(1'b0, 16'h0060);
    waitClk(15);
    check("R3 stop on line 9", 32'(ctrlRd), 32'h40E9);
    check("R5 irq after stop", 32'(irq), 32'h1);

    // R9 line-status write while scan enabled is ignored
    ring[2] = 1'b1;
    busWrite(1'b1, 16'h0001);
    check("R9 line enable untouched", 32'(lineEnOut[9]), 32'h0);
    check("R9 lineRd line9", 32'(lineRd), 32'h40);

    // R6 restart; R4 change made while stopped gets reported
    busWrite(1'b0, 16'h0060);
    check("R6 restart clears done and flags", 32'(ctrlRd), 32'h0060);
    waitClk(6);
    check("R4 ring on line 2 reported", 32'(ctrlRd), 32'h80E2);

    // R2 wrap from 15 to 0
    busWrite(1'b0, 16'h006E);
    check("R2 start at 14", 32'(ctrlRd), 32'h006E);
    waitClk(2);
    check("R2 wrapped to 0 busy", 32'(ctrlRd), 32'h0070);

    // R12 control write collides with a detecting step
    busWrite(1'b0, 16'h0064);
    cts[4] = 1'b1;
    busWrite(1'b0, 16'h0004);
    check("R12 write wins, no report", 32'(ctrlRd), 32'h0004);
    busWrite(1'b0, 16'h0064);
    waitClk(3);
    check("R12 change reported later", 32'(ctrlRd), 32'h20E4);

    // R7 forced interrupt
    busWrite(1'b0, 16'h0000);
    busWrite(1'b0, 16'h00C0);
    check("R7 forced irq", 32'(irq), 32'h1);
    waitClk(3);
    check("R7 no scanning", 32'(ctrlRd), 32'h00C0);

    // R10 clear scan keeps outputs
    busWrite(1'b0, 16'h0840);
    check("R10 ctrl cleared", 32'(ctrlRd), 32'h0040);
    check("R10 outputs kept", 32'(dtrOut[5]), 32'h1);

    // R11 clear multiplexer
    busWrite(1'b0, 16'h0400);
    check("R11 ctrl cleared", 32'(ctrlRd), 32'h0000);
    check("R11 outputs zero", {dtrOut, rtsOut}, 32'h0);

    waitClk(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule